// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is a behavioural, synthesizable model of one programmable logic cell, of the kind placed behind a product-term array. A sum of products is formed from up to sixteen product terms, selected by an allocation mask. A single storage element then registers or latches this sum, or the sum passes straight through. The result is driven toward a pin with a selectable polarity and a selectable output enable. It is also returned to the interconnect on a feedback path that never goes through the pin. The pin's own input value comes back on a separate path, so a pin that is not driven can still serve as an input.

All configuration inputs are static. They may only change while `rst` is held. Clock sources, block preset and block reset are modelled relative to a fast core clock `clk`. A clock source "edge" is a rising transition of the chosen source seen between two core clock edges. The storage element acts on the core edge at which that rise is first seen. Preset and reset act on the next core edge regardless of the chosen source. A parameter selects the buried variant. A buried cell never drives its pin and can capture the neighbouring cell's pin input in place of the sum of products.

Top module: `mc_cell`

## Requirements
- R1: The sum of products is the OR of `pterms[i]` over every bit `i` set in `pterm_alloc`. With no bits allocated it is 0. In combinational mode (`cfg_store` = 0) `fb_out` equals it in the same cycle.
- R2: In D mode (`cfg_store` = 1) the stored value takes the data input at the core edge where the selected clock source is first seen high after being low. Otherwise it holds, including while the source stays high.
- R3: In T mode (`cfg_store` = 2) the stored value inverts on such a source edge when the data input is 1. It holds when the data input is 0.
- R4: In latch mode (`cfg_store` = 3) the stored value follows the data input, one core cycle later, while the selected source is high. It holds while the source is low.
- R5: `cfg_clk_sel` values 0 to 3 choose `gclk[0]` to `gclk[3]`, and value 4 chooses `pt_clk`. Transitions on the sources that are not selected have no effect on the stored value.
- R6: `blk_reset` clears the stored value and `blk_preset` sets it, at the next core edge, with no clock source edge needed. Reset wins when both are high, and preset wins over a simultaneous clock edge.
- R7: `cfg_invert` = 1 makes `pin_out` the complement of the cell output, and `cfg_invert` = 0 passes it unchanged. `fb_out` is never inverted.
- R8: `cfg_oe_sel` picks `pin_oe`: 0 gives constant 0, 1 gives constant 1, 2 gives `oe_lines[0]` and 3 gives `oe_lines[1]`.
- R9: `pin_fb` always equals `pin_in`, whatever the output enable and storage configuration.
- R10: `slow_slew` equals `cfg_slow_slew`.
- R11: In the buried variant `pin_oe` and `pin_out` are always 0. With `cfg_in_reg` = 1 the data input is `nbr_pin_in` in place of the sum of products, and the result appears on `fb_out`. In the pin variant `cfg_in_reg` has no effect.
- R12: While `rst` is high the stored value is cleared and the source edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all sources |
| rst | input | 1 | Synchronous active-high core reset |
| cfg_store | input | 2 | Storage mode: 0 combinational, 1 D, 2 T, 3 latch |
| cfg_clk_sel | input | 3 | Clock source select: 0-3 global, 4 product-term clock |
| cfg_invert | input | 1 | Invert the pin output |
| cfg_oe_sel | input | 2 | Output enable select |
| cfg_slow_slew | input | 1 | Edge-rate configuration bit |
| cfg_in_reg | input | 1 | Buried variant: take data from the neighbouring pin |
| pterms | input | 16 | Product term values |
| pterm_alloc | input | 16 | Mask of product terms allocated to this cell |
| gclk | input | 4 | Shared synchronous clock sources |
| pt_clk | input | 1 | Product-term clock source |
| blk_preset | input | 1 | Block-level preset |
| blk_reset | input | 1 | Block-level reset |
| oe_lines | input | 2 | Shared output enable signals |
| pin_in | input | 1 | Value seen at this cell's pin |
| nbr_pin_in | input | 1 | Value seen at the neighbouring pin |
| pin_out | output | 1 | Data toward the pin after polarity |
| pin_oe | output | 1 | Output enable toward the pin |
| pin_fb | output | 1 | Pin input path to the interconnect |
| fb_out | output | 1 | Cell feedback to the interconnect |
| slow_slew | output | 1 | Edge-rate bit as status |

## Verification
The hardest cases to reach are the contested edges. One is a preset landing on the same core edge as a clock source rise that carries the opposite data. Another is a clock source held high across several core cycles while the data changes. The stimulus reaches these by moving data, sources and block controls together at one falling core edge. It then expects the value at the next sampling point. Clock sources the cell has not selected are raised on purpose to show they are ignored. A second, buried instance shares every input, so each buried-mode result can be set beside the pin variant's response to the same stimulus.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        ST_COMB  = 2'd0,
        ST_DFF   = 2'd1,
        ST_TFF   = 2'd2,
        ST_LATCH = 2'd3
    } store_mode_e;

    typedef enum logic [1:0] {
        OE_OFF   = 2'd0,
        OE_ON    = 2'd1,
        OE_LINE0 = 2'd2,
        OE_LINE1 = 2'd3
    } oe_sel_e;

    typedef struct packed {
        store_mode_e store;
        logic        invert;
        oe_sel_e     oe_sel;
        logic        in_reg;
    } cell_cfg_t;

    // Value the element takes on a qualifying clock event
    function automatic logic store_next(store_mode_e mode, logic q, logic d);
        case (mode)
            ST_DFF:   return d;
            ST_TFF:   return q ^ d;
            ST_LATCH: return d;
            default:  return q;
        endcase
    endfunction

    function automatic logic oe_pick(oe_sel_e sel, logic [1:0] lines);
        case (sel)
            OE_OFF:   return 1'b0;
            OE_ON:    return 1'b1;
            OE_LINE0: return lines[0];
            default:  return lines[1];
        endcase
    endfunction

endpackage

// File: rtl/mc_sop.sv
module mc_sop #(
    parameter int N_TERMS = 16
) (
    input  logic [N_TERMS-1:0] terms,
    input  logic [N_TERMS-1:0] alloc,
    output logic               sop
);
    assign sop = |(terms & alloc);
endmodule

// File: rtl/mc_clksel.sv
module mc_clksel #(
    parameter int N_GCLK = 4,
    parameter int SEL_W  = $clog2(N_GCLK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    output logic              src_level,
    output logic              src_rise
);
    logic src_prev;

    always_comb begin
        src_level = 1'b0;
        for (int i = 0; i < N_GCLK; i++) begin
            if (sel == SEL_W'(i)) src_level = gclk[i];
        end
        if (sel == SEL_W'(N_GCLK)) src_level = pt_clk;
    end

    always_ff @(posedge clk) begin
        if (rst) src_prev <= 1'b0;
        else     src_prev <= src_level;
    end

    assign src_rise = src_level & ~src_prev;
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  store_mode_e mode,
    input  logic        d,
    input  logic        src_level,
    input  logic        src_rise,
    input  logic        preset,
    input  logic        reset,
    output logic        q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (reset) begin
            q <= 1'b0;
        end else if (preset) begin
            q <= 1'b1;
        end else begin
            case (mode)
                ST_DFF, ST_TFF: if (src_rise)  q <= store_next(mode, q, d);
                ST_LATCH:       if (src_level) q <= store_next(mode, q, d);
                default:        q <= q;
            endcase
        end
    end

    a_r6_reset_wins: assert property (@(posedge clk) disable iff (rst)
        reset |=> !q);
    a_r6_preset_sets: assert property (@(posedge clk) disable iff (rst)
        (preset && !reset) |=> q);
    a_r2_dff_capture: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_DFF && src_rise && !preset && !reset) |=> (q == $past(d)));
    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_TFF && src_rise && d && !preset && !reset) |=> (q != $past(q)));
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_LATCH && !src_level && !preset && !reset) |=> $stable(q));
endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
#(
    parameter int N_TERMS   = 16,
    parameter int N_GCLK    = 4,
    parameter bit IS_BURIED = 1'b0,
    localparam int SEL_W    = $clog2(N_GCLK + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_store,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic               cfg_invert,
    input  logic [1:0]         cfg_oe_sel,
    input  logic               cfg_slow_slew,
    input  logic               cfg_in_reg,
    input  logic [N_TERMS-1:0] pterms,
    input  logic [N_TERMS-1:0] pterm_alloc,
    input  logic [N_GCLK-1:0]  gclk,
    input  logic               pt_clk,
    input  logic               blk_preset,
    input  logic               blk_reset,
    input  logic [1:0]         oe_lines,
    input  logic               pin_in,
    input  logic               nbr_pin_in,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               pin_fb,
    output logic               fb_out,
    output logic               slow_slew
);
    cell_cfg_t cfg;
    logic      sop;
    logic      data;
    logic      src_level;
    logic      src_rise;
    logic      q;
    logic      cell_val;

    assign cfg.store  = store_mode_e'(cfg_store);
    assign cfg.invert = cfg_invert;
    assign cfg.oe_sel = oe_sel_e'(cfg_oe_sel);
    assign cfg.in_reg = cfg_in_reg;

    mc_sop #(.N_TERMS(N_TERMS)) u_sop (
        .terms (pterms),
        .alloc (pterm_alloc),
        .sop   (sop)
    );

    // Input-register path exists only in the buried variant
    assign data = (IS_BURIED && cfg.in_reg) ? nbr_pin_in : sop;

    mc_clksel #(.N_GCLK(N_GCLK), .SEL_W(SEL_W)) u_clksel (
        .clk       (clk),
        .rst       (rst),
        .sel       (cfg_clk_sel),
        .gclk      (gclk),
        .pt_clk    (pt_clk),
        .src_level (src_level),
        .src_rise  (src_rise)
    );

    mc_store u_store (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg.store),
        .d         (data),
        .src_level (src_level),
        .src_rise  (src_rise),
        .preset    (blk_preset),
        .reset     (blk_reset),
        .q         (q)
    );

    assign cell_val  = (cfg.store == ST_COMB) ? data : q;
    assign fb_out    = cell_val;
    assign pin_fb    = pin_in;
    assign slow_slew = cfg_slow_slew;

    generate
        if (IS_BURIED) begin : g_buried
            logic unused_pin_ctl;
            assign unused_pin_ctl = cfg.invert ^ (^cfg.oe_sel) ^ (^oe_lines);
            assign pin_out = 1'b0;
            assign pin_oe  = 1'b0;
        end else begin : g_pin
            assign pin_out = cell_val ^ cfg.invert;
            assign pin_oe  = oe_pick(cfg.oe_sel, oe_lines);
        end
    endgenerate

    a_r11_buried_quiet: assert property (@(posedge clk) disable iff (rst)
        (IS_BURIED && cfg.in_reg && cfg.store == ST_DFF && src_rise && !blk_preset && !blk_reset)
        |=> (fb_out == $past(nbr_pin_in)));
endmodule

// File: tb/tb_mc_cell.sv
`timescale 1ns/1ps
module tb_mc_cell;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_store = 2'd1;
    logic [2:0]  cfg_clk_sel = 3'd0;
    logic        cfg_invert = 1'b0;
    logic [1:0]  cfg_oe_sel = 2'd1;
    logic        cfg_slow_slew = 1'b0;
    logic        cfg_in_reg = 1'b0;
    logic [15:0] pterms = '0;
    logic [15:0] pterm_alloc = 16'h0001;
    logic [3:0]  gclk = '0;
    logic        pt_clk = 1'b0;
    logic        blk_preset = 1'b0;
    logic        blk_reset = 1'b0;
    logic [1:0]  oe_lines = '0;
    logic        pin_in = 1'b0;
    logic        nbr_pin_in = 1'b0;

    logic pin_out, pin_oe, pin_fb, fb_out, slow_slew;
    logic b_pin_out, b_pin_oe, b_pin_fb, b_fb_out, b_slow_slew;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mc_cell dut (
        .clk(clk), .rst(rst), .cfg_store(cfg_store), .cfg_clk_sel(cfg_clk_sel),
        .cfg_invert(cfg_invert), .cfg_oe_sel(cfg_oe_sel), .cfg_slow_slew(cfg_slow_slew),
        .cfg_in_reg(cfg_in_reg), .pterms(pterms), .pterm_alloc(pterm_alloc),
        .gclk(gclk), .pt_clk(pt_clk), .blk_preset(blk_preset), .blk_reset(blk_reset),
        .oe_lines(oe_lines), .pin_in(pin_in), .nbr_pin_in(nbr_pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_fb(pin_fb), .fb_out(fb_out),
        .slow_slew(slow_slew)
    );

    mc_cell #(.IS_BURIED(1'b1)) dut_bur (
        .clk(clk), .rst(rst), .cfg_store(cfg_store), .cfg_clk_sel(cfg_clk_sel),
        .cfg_invert(cfg_invert), .cfg_oe_sel(cfg_oe_sel), .cfg_slow_slew(cfg_slow_slew),
        .cfg_in_reg(cfg_in_reg), .pterms(pterms), .pterm_alloc(pterm_alloc),
        .gclk(gclk), .pt_clk(pt_clk), .blk_preset(blk_preset), .blk_reset(blk_reset),
        .oe_lines(oe_lines), .pin_in(pin_in), .nbr_pin_in(nbr_pin_in),
        .pin_out(b_pin_out), .pin_oe(b_pin_oe), .pin_fb(b_pin_fb), .fb_out(b_fb_out),
        .slow_slew(b_slow_slew)
    );

    // Observed bits: [6] pin_out [5] fb_out [4] pin_oe [3] pin_fb
    //                [2] slow_slew [1] buried fb_out [0] buried pin_oe|pin_out
    typedef struct {
        logic [6:0] care;
        logic [6:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t cur;
    logic [6:0] act;

    // Driver side: called at a falling edge after inputs are set
    task automatic step(input logic [6:0] care, input logic [6:0] exp, input string tag);
        sb_item_t it;
        it.care = care;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic cfg_apply(input logic [1:0] st, input logic [2:0] cs, input logic inv,
                             input logic [1:0] oes, input logic slw, input logic inr);
        rst = 1'b1;
        gclk = '0; pt_clk = 1'b0; blk_preset = 1'b0; blk_reset = 1'b0;
        cfg_store = st; cfg_clk_sel = cs; cfg_invert = inv;
        cfg_oe_sel = oes; cfg_slow_slew = slw; cfg_in_reg = inr;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compares between the rising and falling core edges
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            act = {pin_out, fb_out, pin_oe, pin_fb, slow_slew, b_fb_out, b_pin_oe | b_pin_out};
            checks++;
            if ((act & cur.care) !== (cur.exp & cur.care)) begin
                fails++;
                $display("FAIL %s: actual %b expected %b (care %b)", cur.tag,
                         act & cur.care, cur.exp & cur.care, cur.care);
            end
        end
    end

    localparam logic [6:0] FB  = 7'b0100000;
    localparam logic [6:0] PO  = 7'b1000000;
    localparam logic [6:0] OE  = 7'b0010000;
    localparam logic [6:0] PF  = 7'b0001000;
    localparam logic [6:0] SL  = 7'b0000100;
    localparam logic [6:0] BF  = 7'b0000010;
    localparam logic [6:0] BQ  = 7'b0000001;

    initial begin
        @(negedge clk);
        // R12: reset state
        cfg_apply(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        step(7'h7F, OE, "R12 reset state");

        // R1: sum of products in combinational mode
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        pterm_alloc = 16'h00F0; pterms = 16'h0010;
        step(PO | FB | BF, PO | FB | BF, "R1 allocated term high");
        pterms = 16'h000F;
        step(PO | FB | BF, 7'b0, "R1 only unallocated terms high");
        pterm_alloc = 16'h0000; pterms = 16'hFFFF;
        step(FB, 7'b0, "R1 nothing allocated");
        pterm_alloc = 16'hFFFF; pterms = 16'h8000;
        step(FB, FB, "R1 top term");

        // R7: polarity
        cfg_apply(2'd0, 3'd0, 1'b1, 2'd1, 1'b0, 1'b0);
        step(PO | FB, FB, "R7 inverted high");
        pterms = 16'h0000;
        step(PO | FB, PO, "R7 inverted low");

        // R2: D mode on gclk[0]
        cfg_apply(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        pterm_alloc = 16'h0001; pterms = 16'h0001;
        step(FB, 7'b0, "R2 no edge yet");
        gclk[0] = 1'b1;
        step(FB | PO, FB | PO, "R2 capture on rise");
        pterms = 16'h0000;
        step(FB, FB, "R2 source held high");
        gclk[0] = 1'b0;
        step(FB, FB, "R2 source falls");
        gclk[0] = 1'b1;
        step(FB, 7'b0, "R2 capture zero");

        // R5: clock selection
        cfg_apply(2'd1, 3'd2, 1'b0, 2'd1, 1'b0, 1'b0);
        pterms = 16'h0001;
        gclk = 4'b0001;
        step(FB, 7'b0, "R5 unselected gclk0 ignored");
        gclk = 4'b0000;
        step(FB, 7'b0, "R5 still zero");
        gclk = 4'b0100;
        step(FB, FB, "R5 gclk2 selected");
        cfg_apply(2'd1, 3'd4, 1'b0, 2'd1, 1'b0, 1'b0);
        gclk = 4'b1111;
        step(FB, 7'b0, "R5 globals ignored under pt clock");
        pt_clk = 1'b1;
        step(FB, FB, "R5 pt clock captures");

        // R3: T mode
        cfg_apply(2'd2, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        pterms = 16'h0001;
        gclk[0] = 1'b1;
        step(FB, FB, "R3 toggle to one");
        gclk[0] = 1'b0;
        step(FB, FB, "R3 hold between edges");
        gclk[0] = 1'b1;
        step(FB, 7'b0, "R3 toggle to zero");
        gclk[0] = 1'b0; pterms = 16'h0000;
        step(FB, 7'b0, "R3 low phase");
        gclk[0] = 1'b1;
        step(FB, 7'b0, "R3 hold when data zero");

        // R4: latch on gclk[1]
        cfg_apply(2'd3, 3'd1, 1'b0, 2'd1, 1'b0, 1'b0);
        pterms = 16'h0001; gclk[1] = 1'b1;
        step(FB, FB, "R4 transparent high");
        pterms = 16'h0000;
        step(FB, 7'b0, "R4 follows while open");
        gclk[1] = 1'b0; pterms = 16'h0001;
        step(FB, 7'b0, "R4 closed holds");
        step(FB, 7'b0, "R4 closed still holds");

        // R6: block preset and reset
        cfg_apply(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        pterms = 16'h0000;
        blk_preset = 1'b1;
        step(FB, FB, "R6 preset without clock");
        blk_reset = 1'b1;
        step(FB, 7'b0, "R6 reset wins over preset");
        blk_preset = 1'b0; blk_reset = 1'b0;
        step(FB, 7'b0, "R6 hold after release");
        blk_preset = 1'b1; gclk[0] = 1'b1;
        step(FB, FB, "R6 preset beats clock edge");
        blk_preset = 1'b0; gclk[0] = 1'b0;
        step(FB, FB, "R6 hold after preset");
        blk_reset = 1'b1;
        step(FB, 7'b0, "R6 reset alone");
        blk_reset = 1'b0;

        // R8: output enable select
        oe_lines = 2'b10;
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        step(OE, 7'b0, "R8 sel 0 constant off");
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        step(OE, OE, "R8 sel 1 constant on");
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd2, 1'b0, 1'b0);
        step(OE, 7'b0, "R8 sel 2 line0");
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd3, 1'b0, 1'b0);
        step(OE, OE, "R8 sel 3 line1");
        oe_lines = 2'b01;
        step(OE, 7'b0, "R8 sel 3 line1 low");

        // R9: pin input path
        pin_in = 1'b1;
        step(PF | OE, PF, "R9 pin input while not driven");
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        step(PF | OE, PF | OE, "R9 pin input while driven");
        pin_in = 1'b0;
        step(PF, 7'b0, "R9 pin input low");

        // R10: slew status
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd1, 1'b1, 1'b0);
        step(SL, SL, "R10 slow slew");
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        step(SL, 7'b0, "R10 fast slew");

        // R11: buried variant as input register
        cfg_apply(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 1'b1);
        pterms = 16'h0000; nbr_pin_in = 1'b1; gclk[0] = 1'b1;
        step(FB | BF | BQ, BF, "R11 buried captures neighbour pin");
        cfg_apply(2'd3, 3'd0, 1'b0, 2'd1, 1'b0, 1'b1);
        nbr_pin_in = 1'b1; gclk[0] = 1'b1;
        step(BF | BQ, BF, "R11 buried latch open");
        gclk[0] = 1'b0; nbr_pin_in = 1'b0;
        step(BF | BQ, BF, "R11 buried latch holds");
        cfg_apply(2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        pterms = 16'h0001; nbr_pin_in = 1'b0;
        step(FB | BF | BQ, FB | BF, "R11 buried uses sum when not input register");

        // R12: core reset clears a stored one
        cfg_apply(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        gclk[0] = 1'b1;
        step(FB, FB, "R12 stored one");
        cfg_apply(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        step(FB, 7'b0, "R12 cleared by reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule